// File: doc/BRIEF.md
# Latched 16-bit Down-Counter Channel

This block is one programmable 16-bit down counter behind a byte-wide processor port. Software first writes a control byte. The control byte says which channel it addresses and how the channel's bytes are moved: low byte only, high byte only, or low byte then high byte. A control byte can also be a snapshot request. After the control byte, software writes the starting count one byte at a time. The counter steps down once for every rising edge of a synchronous count-enable input, but only while the gate input is high. When a step takes the count from one to zero, a terminal-count pulse is raised.

Reading a running counter byte by byte is not safe, because a borrow can move between the two bytes while they are being read. A snapshot request copies the live count into a hold register in a single cycle. The next reads come from the hold register while counting goes on. When all bytes of the snapshot have been read in the current byte mode, reads follow the live count again. Another way to get a stable direct read or load is to hold the gate low.

Top module: `dcnt_chan`

## Requirements
- R1: Reset sets the count, the hold register and the read data output to 0. It clears the terminal-count output, drops any snapshot, sets both byte toggles to "low first" and selects the low-then-high byte mode.
- R2: A control write (address 1) is acted on only when bits 7:6 equal the channel number parameter; any other value leaves the channel untouched. Bits 5:4 select the access: 00 = snapshot, 01 = low byte only, 10 = high byte only, 11 = low then high. Bits 3:0 have no effect.
- R3: A data write (address 0) in low-only mode loads {0x00, byte}, and in high-only mode loads {byte, 0x00}. In low-then-high mode the first write is staged as the low byte, and the count changes only when the second write supplies the high byte.
- R4: A control write that is not a snapshot resets both the write toggle and the read toggle to "low first", and it releases any pending snapshot.
- R5: With the gate high, each rising edge of the count-enable input lowers the count by one. A data write that loads the count in the same cycle takes priority over the step.
- R6: While the gate is low, count-enable edges leave the count unchanged.
- R7: A snapshot copies the live count into the hold register in one cycle. Data reads then return bytes of the held value, and counting continues meanwhile.
- R8: A snapshot stays in force until one read in low-only or high-only mode, or two reads in low-then-high mode. Snapshot requests made while one is pending are ignored.
- R9: A data read returns a byte chosen by the byte mode; low-then-high mode alternates low then high. The read data is registered and valid in the cycle after the read strobe. A read of address 1 returns 0x00.
- R10: The terminal-count output is high for exactly one cycle after a step from 1 to 0. A step from 0 wraps to 0xFFFF and does not raise it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_wr | input | 1 | Write strobe, one cycle per byte |
| cpu_rd | input | 1 | Read strobe, one cycle per byte |
| cpu_addr | input | 1 | 0 = count data, 1 = control |
| cpu_wdata | input | 8 | Write byte |
| cpu_rdata | output | 8 | Registered read byte |
| cnt_en | input | 1 | Synchronous count-enable; a step on each rising edge |
| gate | input | 1 | Count inhibit when low |
| tc_pulse | output | 1 | One-cycle terminal-count pulse |

## Verification
The bound checker checks these on every cycle:
- the terminal-count pulse lines up with a zero count and never lasts two cycles;
- the count stays unchanged while the gate is low, and drops by exactly one on an accepted step;
- a snapshot captures the count of the cycle before;
- the hold register stays fixed while a snapshot is pending;
- control bytes for another channel leave the byte mode alone.

Only the bench scenarios can show the byte-order effects. These are the staged low byte, the toggles reset by a new control word, a snapshot released by the right number of reads, a second snapshot being ignored, and the wrap without a pulse.

// File: rtl/dcnt_pkg.sv
package dcnt_pkg;
  // access field of the control byte
  typedef enum logic [1:0] {
    ACC_SNAP = 2'b00,
    ACC_LO   = 2'b01,
    ACC_HI   = 2'b10,
    ACC_LOHI = 2'b11
  } acc_mode_e;
endpackage

// File: rtl/dcnt_ctl_dec.sv
module dcnt_ctl_dec
  import dcnt_pkg::*;
#(
  parameter int unsigned SEL_W   = 2,
  parameter int unsigned CHAN_ID = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_ctl,
  input  logic [SEL_W-1:0] sel,
  input  logic [1:0]       acc_field,
  output logic             snap_cmd,
  output logic             prog_cmd,
  output acc_mode_e        acc_q
);
  localparam logic [SEL_W-1:0] MY_ID = SEL_W'(CHAN_ID);

  logic hit;

  always_comb begin
    hit      = wr_ctl && (sel == MY_ID);
    snap_cmd = hit && (acc_field == 2'b00);
    prog_cmd = hit && (acc_field != 2'b00);
  end

  always_ff @(posedge clk) begin
    if (rst)           acc_q <= ACC_LOHI;
    else if (prog_cmd) acc_q <= acc_mode_e'(acc_field);
  end
endmodule

// File: rtl/dcnt_load_seq.sv
module dcnt_load_seq
  import dcnt_pkg::*;
#(
  parameter int unsigned BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_dat,
  input  logic [BYTE_W-1:0]   wdata,
  input  acc_mode_e           acc,
  input  logic                prog_cmd,
  output logic                load_fire,
  output logic [2*BYTE_W-1:0] load_val
);
  logic              wr_tog;
  logic [BYTE_W-1:0] lo_stage;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_tog   <= 1'b0;
      lo_stage <= '0;
    end else if (prog_cmd) begin
      wr_tog <= 1'b0;
    end else if (wr_dat && acc == ACC_LOHI) begin
      if (!wr_tog) begin
        lo_stage <= wdata;
        wr_tog   <= 1'b1;
      end else begin
        wr_tog <= 1'b0;
      end
    end
  end

  always_comb begin
    load_fire = 1'b0;
    load_val  = '0;
    case (acc)
      ACC_LO: begin
        load_fire = wr_dat;
        load_val  = {{BYTE_W{1'b0}}, wdata};
      end
      ACC_HI: begin
        load_fire = wr_dat;
        load_val  = {wdata, {BYTE_W{1'b0}}};
      end
      ACC_LOHI: begin
        load_fire = wr_dat && wr_tog;
        load_val  = {wdata, lo_stage};
      end
      default: begin
        load_fire = 1'b0;
        load_val  = '0;
      end
    endcase
  end
endmodule

// File: rtl/dcnt_core.sv
module dcnt_core #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cnt_en,
  input  logic             gate,
  input  logic             load_fire,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] cnt_q,
  output logic             tc_q
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic en_q;
  logic step;

  // previous sample of count-enable; follows the input even in reset
  always_ff @(posedge clk) en_q <= cnt_en;

  always_comb step = gate && cnt_en && !en_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      tc_q  <= 1'b0;
    end else begin
      tc_q <= !load_fire && step && (cnt_q == ONE);
      if (load_fire)  cnt_q <= load_val;
      else if (step)  cnt_q <= cnt_q - ONE;
    end
  end
endmodule

// File: rtl/dcnt_read_port.sv
module dcnt_read_port
  import dcnt_pkg::*;
#(
  parameter int unsigned BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                snap_cmd,
  input  logic                prog_cmd,
  input  logic                rd_dat,
  input  logic                rd_ctl,
  input  acc_mode_e           acc,
  input  logic [2*BYTE_W-1:0] cnt,
  output logic [BYTE_W-1:0]   rdata_q,
  output logic [2*BYTE_W-1:0] hold_q,
  output logic                held_q
);
  logic                rd_tog;
  logic [2*BYTE_W-1:0] src;

  always_comb src = held_q ? hold_q : cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
      hold_q  <= '0;
      held_q  <= 1'b0;
      rd_tog  <= 1'b0;
    end else begin
      if (prog_cmd) begin
        held_q <= 1'b0;
        rd_tog <= 1'b0;
      end else if (snap_cmd && !held_q) begin
        hold_q <= cnt;
        held_q <= 1'b1;
      end
      if (rd_ctl) begin
        rdata_q <= '0;
      end else if (rd_dat) begin
        case (acc)
          ACC_LO: begin
            rdata_q <= src[BYTE_W-1:0];
            held_q  <= 1'b0;
          end
          ACC_HI: begin
            rdata_q <= src[2*BYTE_W-1:BYTE_W];
            held_q  <= 1'b0;
          end
          default: begin
            if (!rd_tog) begin
              rdata_q <= src[BYTE_W-1:0];
              rd_tog  <= 1'b1;
            end else begin
              rdata_q <= src[2*BYTE_W-1:BYTE_W];
              rd_tog  <= 1'b0;
              held_q  <= 1'b0;
            end
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/dcnt_chan.sv
module dcnt_chan
  import dcnt_pkg::*;
#(
  parameter int unsigned BYTE_W  = 8,
  parameter int unsigned SEL_W   = 2,
  parameter int unsigned CHAN_ID = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_wr,
  input  logic              cpu_rd,
  input  logic              cpu_addr,
  input  logic [BYTE_W-1:0] cpu_wdata,
  output logic [BYTE_W-1:0] cpu_rdata,
  input  logic              cnt_en,
  input  logic              gate,
  output logic              tc_pulse
);
  localparam int unsigned CNT_W = 2 * BYTE_W;

  logic             wr_ctl, wr_dat, rd_ctl, rd_dat;
  logic             snap_cmd, prog_cmd, load_fire, held_q, tc_q;
  logic [CNT_W-1:0] load_val, cnt_q, hold_q;
  acc_mode_e        acc_q;

  always_comb begin
    wr_ctl = cpu_wr && cpu_addr;
    wr_dat = cpu_wr && !cpu_addr;
    rd_ctl = cpu_rd && cpu_addr;
    rd_dat = cpu_rd && !cpu_addr;
  end

  dcnt_ctl_dec #(.SEL_W(SEL_W), .CHAN_ID(CHAN_ID)) u_dec (
    .clk(clk), .rst(rst), .wr_ctl(wr_ctl),
    .sel(cpu_wdata[BYTE_W-1 -: SEL_W]),
    .acc_field(cpu_wdata[BYTE_W-SEL_W-1 -: 2]),
    .snap_cmd(snap_cmd), .prog_cmd(prog_cmd), .acc_q(acc_q)
  );

  dcnt_load_seq #(.BYTE_W(BYTE_W)) u_load (
    .clk(clk), .rst(rst), .wr_dat(wr_dat), .wdata(cpu_wdata),
    .acc(acc_q), .prog_cmd(prog_cmd),
    .load_fire(load_fire), .load_val(load_val)
  );

  dcnt_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst(rst), .cnt_en(cnt_en), .gate(gate),
    .load_fire(load_fire), .load_val(load_val),
    .cnt_q(cnt_q), .tc_q(tc_q)
  );

  dcnt_read_port #(.BYTE_W(BYTE_W)) u_rd (
    .clk(clk), .rst(rst), .snap_cmd(snap_cmd), .prog_cmd(prog_cmd),
    .rd_dat(rd_dat), .rd_ctl(rd_ctl), .acc(acc_q), .cnt(cnt_q),
    .rdata_q(cpu_rdata), .hold_q(hold_q), .held_q(held_q)
  );

  assign tc_pulse = tc_q;
endmodule

// File: rtl/dcnt_chk.sv
module dcnt_chk
  import dcnt_pkg::*;
#(
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned SEL_W   = 2,
  parameter int unsigned CHAN_ID = 0
) (
  input logic             clk,
  input logic             rst,
  input logic             cpu_wr,
  input logic             cpu_addr,
  input logic [SEL_W+1:0] ctl_hi,
  input logic             cnt_en,
  input logic             gate,
  input logic             load_fire,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] hold,
  input logic             held,
  input logic             tc,
  input acc_mode_e        acc
);
  localparam logic [SEL_W-1:0] MY_ID = SEL_W'(CHAN_ID);

  logic en_prev;
  always_ff @(posedge clk) en_prev <= cnt_en;

  p_tc_zero_r10: assert property (@(posedge clk) disable iff (rst)
    tc |-> (cnt == '0));

  p_tc_single_r10: assert property (@(posedge clk) disable iff (rst)
    tc |=> !tc);

  p_gate_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (!gate && !load_fire) |=> $stable(cnt));

  p_step_r5: assert property (@(posedge clk) disable iff (rst)
    (gate && cnt_en && !en_prev && !load_fire) |=> (cnt == CNT_W'($past(cnt) - 1'b1)));

  p_snap_copy_r7: assert property (@(posedge clk) disable iff (rst)
    (cpu_wr && cpu_addr && ctl_hi[SEL_W+1:2] == MY_ID && ctl_hi[1:0] == 2'b00 && !held)
      |=> (held && hold == $past(cnt)));

  p_hold_fixed_r8: assert property (@(posedge clk) disable iff (rst)
    held |=> $stable(hold));

  p_foreign_r2: assert property (@(posedge clk) disable iff (rst)
    (cpu_wr && cpu_addr && ctl_hi[SEL_W+1:2] != MY_ID) |=> $stable(acc));
endmodule

bind dcnt_chan dcnt_chk #(.CNT_W(2*BYTE_W), .SEL_W(SEL_W), .CHAN_ID(CHAN_ID)) u_chk (
  .clk(clk), .rst(rst), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
  .ctl_hi(cpu_wdata[BYTE_W-1 -: SEL_W+2]), .cnt_en(cnt_en), .gate(gate),
  .load_fire(load_fire), .cnt(cnt_q), .hold(hold_q), .held(held_q),
  .tc(tc_q), .acc(acc_q)
);

// File: tb/tb_dcnt_chan.sv
`timescale 1ns/1ps
module tb_dcnt_chan;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cpu_wr = 1'b0, cpu_rd = 1'b0, cpu_addr = 1'b0;
  logic [7:0] cpu_wdata = '0;
  logic [7:0] cpu_rdata;
  logic       cnt_en = 1'b0, gate = 1'b1;
  logic       tc_pulse;

  int n_run = 0, n_fail = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic       rd_seen = 1'b0;

  always #4 clk = ~clk;

  dcnt_chan dut (
    .clk(clk), .rst(rst), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .cnt_en(cnt_en), .gate(gate), .tc_pulse(tc_pulse)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: compare each read result one cycle after its strobe
  always @(posedge clk) rd_seen <= cpu_rd;
  always @(negedge clk) begin
    if (rd_seen) begin
      if (exp_q.size() == 0) chk(1'b0, "R9 unexpected read", cpu_rdata, 0);
      else chk(cpu_rdata == exp_q[0], tag_q[0], cpu_rdata, exp_q[0]);
      if (exp_q.size() != 0) begin
        void'(exp_q.pop_front());
        void'(tag_q.pop_front());
      end
    end
  end

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk); cpu_wr = 1'b1; cpu_addr = a; cpu_wdata = d;
    @(negedge clk); cpu_wr = 1'b0;
  endtask

  task automatic rd(input logic a, input logic [7:0] e, input string tag);
    @(negedge clk); exp_q.push_back(e); tag_q.push_back(tag);
    cpu_rd = 1'b1; cpu_addr = a;
    @(negedge clk); cpu_rd = 1'b0;
  endtask

  task automatic pulse(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); cnt_en = 1'b1;
      @(negedge clk); cnt_en = 1'b0;
    end
  endtask

  task automatic tc_step(input logic exp_tc);
    @(negedge clk); cnt_en = 1'b1;
    @(negedge clk); chk(tc_pulse == exp_tc, "R10 tc after step", tc_pulse, exp_tc);
    cnt_en = 1'b0;
    @(negedge clk); chk(tc_pulse == 1'b0, "R10 tc one cycle", tc_pulse, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    chk(cpu_rdata == 8'h00, "R1 rdata", cpu_rdata, 0);
    chk(tc_pulse == 1'b0, "R1 tc", tc_pulse, 0);
    rst = 1'b0;
    rd(1'b0, 8'h00, "R1 count low");
    rd(1'b0, 8'h00, "R1 count high");
    rd(1'b1, 8'h00, "R9 control read");

    // full-scale load, snapshot while counting
    wr(1'b1, 8'h30); wr(1'b0, 8'hFF); wr(1'b0, 8'hFF);
    pulse(3);
    wr(1'b1, 8'h00);
    pulse(5);
    rd(1'b0, 8'hFC, "R7 held low");
    rd(1'b0, 8'hFF, "R7 held high");
    rd(1'b0, 8'hF7, "R8 live low after release");
    rd(1'b0, 8'hFF, "R8 live high after release");

    // second snapshot ignored
    wr(1'b1, 8'h00); pulse(2);
    wr(1'b1, 8'h00); pulse(2);
    rd(1'b0, 8'hF7, "R8 first snapshot kept low");
    rd(1'b0, 8'hFF, "R8 first snapshot kept high");
    rd(1'b0, 8'hF3, "R8 live low");
    rd(1'b0, 8'hFF, "R8 live high");

    // gate low
    @(negedge clk); gate = 1'b0;
    pulse(4);
    @(negedge clk); gate = 1'b1;
    rd(1'b0, 8'hF3, "R6 gated low");
    rd(1'b0, 8'hFF, "R6 gated high");

    // staged low byte
    wr(1'b0, 8'h34);
    rd(1'b0, 8'hF3, "R3 staged not applied low");
    rd(1'b0, 8'hFF, "R3 staged not applied high");
    wr(1'b0, 8'h12);
    rd(1'b0, 8'h34, "R3 pair low");
    rd(1'b0, 8'h12, "R3 pair high");

    // control word resets toggles and releases a snapshot
    wr(1'b0, 8'hAA); wr(1'b1, 8'h30); wr(1'b0, 8'h11); wr(1'b0, 8'h22);
    rd(1'b0, 8'h11, "R4 write toggle low");
    wr(1'b1, 8'h30);
    rd(1'b0, 8'h11, "R4 read toggle reset");
    rd(1'b0, 8'h22, "R4 high after reset");
    wr(1'b1, 8'h00); pulse(1); wr(1'b1, 8'h30);
    rd(1'b0, 8'h10, "R4 snapshot dropped low");
    rd(1'b0, 8'h22, "R4 snapshot dropped high");

    // other channel select and ignored low bits
    wr(1'b1, 8'h50);
    rd(1'b0, 8'h10, "R2 foreign mode low");
    rd(1'b0, 8'h22, "R2 foreign mode high");
    wr(1'b1, 8'h40); pulse(1);
    rd(1'b0, 8'h0F, "R2 foreign snapshot low");
    rd(1'b0, 8'h22, "R2 foreign snapshot high");
    wr(1'b1, 8'h3F); wr(1'b0, 8'h78); wr(1'b0, 8'h56);
    rd(1'b0, 8'h78, "R2 low bits ignored low");
    rd(1'b0, 8'h56, "R2 low bits ignored high");

    // single-byte modes
    wr(1'b1, 8'h10); wr(1'b0, 8'h05);
    rd(1'b0, 8'h05, "R3 low-only load");
    wr(1'b1, 8'h20);
    rd(1'b0, 8'h00, "R9 high-only read");
    wr(1'b0, 8'h12);
    rd(1'b0, 8'h12, "R3 high-only load");
    wr(1'b1, 8'h10);
    rd(1'b0, 8'h00, "R3 high-only zero low");
    wr(1'b1, 8'h00); pulse(1);
    rd(1'b0, 8'h00, "R8 low-only held");
    rd(1'b0, 8'hFF, "R8 low-only released");

    // terminal count and wrap
    wr(1'b1, 8'h30); wr(1'b0, 8'h02); wr(1'b0, 8'h00);
    tc_step(1'b0);
    tc_step(1'b1);
    rd(1'b0, 8'h00, "R10 zero low");
    rd(1'b0, 8'h00, "R10 zero high");
    tc_step(1'b0);
    rd(1'b0, 8'hFF, "R10 wrap low");
    rd(1'b0, 8'hFF, "R10 wrap high");

    // load beats a step in the same cycle
    wr(1'b1, 8'h10);
    @(negedge clk); cnt_en = 1'b1; cpu_wr = 1'b1; cpu_addr = 1'b0; cpu_wdata = 8'h07;
    @(negedge clk); cnt_en = 1'b0; cpu_wr = 1'b0;
    wr(1'b1, 8'h30);
    rd(1'b0, 8'h07, "R5 load priority low");
    rd(1'b0, 8'h00, "R5 load priority high");

    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R9 all reads returned", exp_q.size(), 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule